// File: doc/BRIEF.md
# Cache Slice Activation Controller

This block holds an on/off state for each cache slice (up to 32) inside every bank of a banked cache. Software controls a slice by writing its control word: a trigger bit plus a two-bit opcode asking for activation or deactivation. A rising edge of the trigger, seen across two successive control writes to the same slice, starts a transition. The transition lasts a fixed number of cycles. Software then polls the slice's status word until the bit for the old state drops.

All writes arrive on one broadcast port and are applied to every bank at once. Each bank keeps its own per-slice state machines and its own trigger history. A read port chooses a bank and an address and returns that bank's status word for the addressed slice. Control words cannot be read back.

Top module: `slc_act_ctrl`

## Requirements
- R1: After a synchronous reset, every slice in every bank reads status 2 (bit 1 "inactive" = 1, bit 0 "active" = 0). The trigger history is cleared, so the first write with the trigger set starts a command.
- R2: In the control word, bit 0 is the trigger and bits [2:1] are the opcode. A command starts only when a control write to a slice has trigger 1 and the previous control write to that slice had trigger 0. A second write that keeps the trigger at 1 starts nothing.
- R3: Opcode 1 (activate) on an inactive slice holds status at 2 for XFER_CYCLES cycles after the starting write. The status then reads 1 (active = 1, inactive = 0).
- R4: Opcode 2 (deactivate) on an active slice holds status at 1 for XFER_CYCLES cycles after the starting write. The status then reads 2.
- R5: Opcodes 0 and 3 never change a slice's state, even when they come with a trigger edge.
- R6: A trigger edge that reaches a slice while it is in transition is ignored. This includes the cycle in which the transition completes. The transition ends at its normal time and in its normal direction.
- R7: The control word of slice n is at byte address n*0x1000 and its status word is at n*0x1000+4. Writes to any other offset, including the status offset, have no effect. Reads of any address other than a status word return 0.
- R8: Every write reaches all banks, and every bank reports the same status for each slice.
- R9: A command to one slice leaves every other slice's status unchanged.
- R10: Activating an active slice, or deactivating an inactive one, leaves its status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Broadcast write strobe |
| wr_addr | input | 17 | Broadcast write byte address |
| wr_data | input | 32 | Write data; bits [2:0] are used |
| rd_bank | input | 1 | Bank selected for reads |
| rd_addr | input | 17 | Read byte address |
| rd_data | output | 32 | Status word of the addressed slice in the selected bank, or 0 |

## Verification
Two things can happen on the same clock edge: a slice's transition finishes, and a new trigger edge arrives for that same slice. The bench forces this case by timing the opposite command so that it lands exactly on the completion edge. The expected result is that the transition completes in its original direction and the late command is dropped, with the status still unchanged several cycles later. A command that lands in the middle of a transition, and commands sent to neighbouring slices while another slice is in transition, are judged in the same way: the status of each affected slice is checked in every bank.

// File: rtl/slc_pkg.sv
package slc_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam logic [PAGE_SHIFT-1:0] OFS_CTRL = 12'h000;
    localparam logic [PAGE_SHIFT-1:0] OFS_STAT = 12'h004;

    typedef enum logic [1:0] {OP_NONE = 2'd0, OP_ACT = 2'd1, OP_DEACT = 2'd2, OP_RSVD = 2'd3} op_e;
    typedef enum logic [1:0] {S_OFF, S_ON, S_TO_ON, S_TO_OFF} slc_state_e;

    typedef struct packed {
        logic trig;
        op_e  op;
    } cmd_t;

    function automatic cmd_t unpack_ctrl(input logic [2:0] w);
        cmd_t c;
        c.trig = w[0];
        c.op   = op_e'(w[2:1]);
        return c;
    endfunction

    // status = {inactive, active}; a slice in transition still shows its old state
    function automatic logic [1:0] state_status(input slc_state_e s);
        case (s)
            S_ON, S_TO_OFF: return 2'b01;
            default:        return 2'b10;
        endcase
    endfunction
endpackage

// File: rtl/slc_addr_dec.sv
module slc_addr_dec
    import slc_pkg::*;
#(
    parameter int NUM_SLICES = 32,
    parameter int SLICE_W    = 5,
    parameter int ADDR_W     = 17
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [SLICE_W-1:0] idx,
    output logic               is_ctrl,
    output logic               is_stat
);
    logic [PAGE_SHIFT-1:0] ofs;
    logic                  in_rng;

    assign ofs     = addr[PAGE_SHIFT-1:0];
    assign idx     = addr[ADDR_W-1:PAGE_SHIFT];
    assign in_rng  = int'(idx) < NUM_SLICES;
    assign is_ctrl = in_rng && (ofs == OFS_CTRL);
    assign is_stat = in_rng && (ofs == OFS_STAT);
endmodule

// File: rtl/slc_slice_fsm.sv
module slc_slice_fsm
    import slc_pkg::*;
#(
    parameter int XFER_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  cmd_t       cmd,
    output logic [1:0] status_o
);
    localparam int CNT_W = $clog2(XFER_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XFER_CYCLES - 1);

    slc_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             trig_q;
    logic             start;
    logic             busy;

    assign start    = cmd_wr && cmd.trig && !trig_q;
    assign busy     = (state == S_TO_ON) || (state == S_TO_OFF);
    assign status_o = state_status(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_OFF;
            cnt    <= '0;
            trig_q <= 1'b0;
        end else begin
            if (cmd_wr) trig_q <= cmd.trig;
            case (state)
                S_OFF: if (start && cmd.op == OP_ACT) begin
                    state <= S_TO_ON;
                    cnt   <= CNT_LOAD;
                end
                S_ON: if (start && cmd.op == OP_DEACT) begin
                    state <= S_TO_OFF;
                    cnt   <= CNT_LOAD;
                end
                S_TO_ON: if (cnt == '0) state <= S_ON; else cnt <= cnt - 1'b1;
                default: if (cnt == '0) state <= S_OFF; else cnt <= cnt - 1'b1;
            endcase
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> status_o == 2'b10);
    p_held_trig_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd.trig && trig_q && !busy) |=> $stable(state));
    p_act_start_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_OFF && start && cmd.op == OP_ACT) |=> (state == S_TO_ON && status_o == 2'b10));
    p_deact_start_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_ON && start && cmd.op == OP_DEACT) |=> (state == S_TO_OFF && status_o == 2'b01));
    p_bad_op_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_wr && (cmd.op == OP_NONE || cmd.op == OP_RSVD)) |=> $stable(state));
    p_no_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> ($stable(state) && $stable(status_o)));
endmodule

// File: rtl/slc_bank.sv
module slc_bank
    import slc_pkg::*;
#(
    parameter int NUM_SLICES  = 32,
    parameter int XFER_CYCLES = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SLICES-1:0]      wr_sel,
    input  cmd_t                       cmd,
    output logic [NUM_SLICES-1:0][1:0] status_o
);
    for (genvar n = 0; n < NUM_SLICES; n++) begin : g_slice
        slc_slice_fsm #(.XFER_CYCLES(XFER_CYCLES)) u_fsm (
            .clk      (clk),
            .rst      (rst),
            .cmd_wr   (wr_sel[n]),
            .cmd      (cmd),
            .status_o (status_o[n])
        );
    end

    p_one_target_r9: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_sel));
endmodule

// File: rtl/slc_act_ctrl.sv
module slc_act_ctrl
    import slc_pkg::*;
#(
    parameter int NUM_BANKS   = 2,
    parameter int NUM_SLICES  = 32,
    parameter int XFER_CYCLES = 4,
    localparam int SLICE_W    = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
    localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W     = PAGE_SHIFT + SLICE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    logic [SLICE_W-1:0] w_idx, r_idx;
    logic               w_ctrl, w_stat_unused, r_ctrl_unused, r_stat;
    logic [NUM_SLICES-1:0] wr_sel;
    logic [NUM_BANKS-1:0][NUM_SLICES-1:0][1:0] all_st;
    cmd_t               cmd;
    logic               data_unused;

    assign data_unused = ^wr_data[31:3];
    assign cmd         = unpack_ctrl(wr_data[2:0]);

    slc_addr_dec #(.NUM_SLICES(NUM_SLICES), .SLICE_W(SLICE_W), .ADDR_W(ADDR_W)) u_wdec (
        .addr(wr_addr), .idx(w_idx), .is_ctrl(w_ctrl), .is_stat(w_stat_unused));
    slc_addr_dec #(.NUM_SLICES(NUM_SLICES), .SLICE_W(SLICE_W), .ADDR_W(ADDR_W)) u_rdec (
        .addr(rd_addr), .idx(r_idx), .is_ctrl(r_ctrl_unused), .is_stat(r_stat));

    for (genvar n = 0; n < NUM_SLICES; n++) begin : g_sel
        assign wr_sel[n] = wr_en && w_ctrl && (w_idx == SLICE_W'(n));
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        slc_bank #(.NUM_SLICES(NUM_SLICES), .XFER_CYCLES(XFER_CYCLES)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (wr_sel),
            .cmd      (cmd),
            .status_o (all_st[b])
        );
    end

    always_comb begin
        rd_data = '0;
        if (r_stat && int'(rd_bank) < NUM_BANKS)
            rd_data[1:0] = all_st[rd_bank][r_idx];
    end

    for (genvar b = 1; b < NUM_BANKS; b++) begin : g_agree
        p_bank_agree_r8: assert property (@(posedge clk) disable iff (rst) all_st[b] == all_st[0]);
    end
    p_rd_zero_r7: assert property (@(posedge clk) disable iff (rst) !r_stat |-> rd_data == '0);
endmodule

// File: tb/sim_slc_act_ctrl.sv
module sim_slc_act_ctrl;
    localparam int XFER = 4;
    localparam int NB   = 2;

    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [16:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_bank = 0;
    logic [16:0] rd_addr = '0;
    logic [31:0] rd_data;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    slc_act_ctrl #(.NUM_BANKS(NB), .NUM_SLICES(32), .XFER_CYCLES(XFER)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data));

    // entries: {slice[4:0], opcode[1:0], expected final status[1:0]}
    localparam logic [8:0] VEC [0:10] = '{
        {5'd5,  2'd1, 2'd1}, {5'd5,  2'd1, 2'd1}, {5'd9,  2'd1, 2'd1},
        {5'd5,  2'd2, 2'd2}, {5'd31, 2'd1, 2'd1}, {5'd0,  2'd3, 2'd2},
        {5'd0,  2'd0, 2'd2}, {5'd31, 2'd2, 2'd2}, {5'd0,  2'd1, 2'd1},
        {5'd9,  2'd2, 2'd2}, {5'd12, 2'd2, 2'd2}};

    function automatic logic [16:0] ctl_a(input int s);
        return 17'(s * 4096);
    endfunction
    function automatic logic [16:0] st_a(input int s);
        return 17'(s * 4096 + 4);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [16:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 0;
    endtask

    task automatic rd_chk(input int b, input logic [16:0] a, input logic [31:0] ex, input string tag);
        rd_bank = 1'(b); rd_addr = a;
        #1;
        tests++;
        if (rd_data !== ex) begin
            fails++;
            $display("FAIL %s bank%0d addr %h: got %h expected %h", tag, b, a, rd_data, ex);
        end
    endtask

    task automatic chk_all(input int s, input logic [1:0] ex, input string tag);
        for (int b = 0; b < NB; b++) rd_chk(b, st_a(s), {30'b0, ex}, tag);
    endtask

    task automatic cmd(input int s, input logic [1:0] op, input bit trig);
        wr(ctl_a(s), {29'b0, op, trig});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0] cur [32];
        for (int s = 0; s < 32; s++) cur[s] = 2'd2;
        tick(3);
        @(negedge clk) rst = 0;
        tick(1);

        // R1: reset state of every slice in every bank
        for (int s = 0; s < 32; s++) chk_all(s, 2'd2, "R1 reset");

        // table walk: R3 R4 R5 R8 R10
        for (int i = 0; i < 11; i++) begin
            int s;
            logic [1:0] op, ex, old;
            string tag;
            s = int'(VEC[i][8:4]); op = VEC[i][3:2]; ex = VEC[i][1:0];
            old = cur[s];
            if (op == 2'd0 || op == 2'd3) tag = "R5";
            else if (old == ex) tag = "R10";
            else if (op == 2'd1) tag = "R3";
            else tag = "R4";
            cmd(s, op, 1);
            chk_all(s, old, tag);
            cmd(s, op, 0);
            tick(XFER - 2);
            chk_all(s, old, tag);
            tick(1);
            chk_all(s, ex, {tag, " R8"});
            cur[s] = ex;
        end
        // R9: slices never commanded, and finished ones, are untouched
        chk_all(6, 2'd2, "R9");
        chk_all(1, 2'd2, "R9");
        chk_all(0, 2'd1, "R9");

        // R2: trigger held high starts nothing
        cmd(3, 2'd1, 1); tick(XFER);
        chk_all(3, 2'd1, "R2 first edge");
        cmd(3, 2'd2, 1); tick(XFER + 2);
        chk_all(3, 2'd1, "R2 held trigger");
        cmd(3, 2'd2, 0); cmd(3, 2'd2, 1); tick(XFER);
        chk_all(3, 2'd2, "R2 new edge");
        cmd(3, 2'd2, 0);

        // R6: edge mid-transition
        cmd(7, 2'd1, 1); cmd(7, 2'd1, 0); cmd(7, 2'd2, 1);
        tick(XFER - 3);
        chk_all(7, 2'd2, "R6 mid");
        tick(1);
        chk_all(7, 2'd1, "R6 completes");
        tick(XFER + 2);
        chk_all(7, 2'd1, "R6 not reversed");
        cmd(7, 2'd2, 0);

        // R6: edge landing on the completion edge
        cmd(8, 2'd1, 1); cmd(8, 2'd1, 0);
        tick(XFER - 2);
        cmd(8, 2'd2, 1);
        chk_all(8, 2'd1, "R6 same-cycle");
        tick(XFER + 2);
        chk_all(8, 2'd1, "R6 same-cycle dropped");
        cmd(8, 2'd2, 0);

        // R7: other offsets ignored, reads elsewhere zero
        wr(17'h0A008, 32'h3); wr(17'h0A008, 32'h2); wr(17'h0A008, 32'h3);
        wr(st_a(10), 32'h3); tick(XFER + 2);
        chk_all(10, 2'd2, "R7 stray writes");
        rd_chk(0, ctl_a(10), 32'h0, "R7 control read");
        rd_chk(1, 17'h0A008, 32'h0, "R7 unmapped read");
        rd_chk(0, st_a(7), 32'h1, "R7 status read");

        // R1: reset again clears state and trigger history
        cmd(4, 2'd1, 1); tick(XFER);
        @(negedge clk) rst = 1;
        tick(2);
        @(negedge clk) rst = 0;
        tick(1);
        chk_all(0, 2'd2, "R1 re-reset");
        chk_all(7, 2'd2, "R1 re-reset");
        cmd(4, 2'd1, 1); tick(XFER);
        chk_all(4, 2'd1, "R1 trigger history cleared");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule